// File: doc/BRIEF.md
# Crosspoint Switch Control Latch Array

This block holds the on/off state of every switch in a crosspoint matrix of 8 columns by 12 rows, one control bit per switch, 96 bits in all. A write names one switch through a 3-bit column address and a 4-bit row address. While the strobe is high, the addressed bit is transparent and follows the data input. When the strobe drops, the bit keeps the data value it last took. Every other bit is left as it was. Any set of switches can be on at the same time, including several in one row or in one column.

The model is synchronous to a fast system clock and keeps the latch behaviour seen at the outputs. The stored bits update on the rising clock edge. The enable output is formed combinationally: it shows the live data input on the addressed bit while the strobe is high, and it shows all zeros while the clear input is high. The clear input empties the whole array and wins over any strobe.

Top module: `xpt_ctrl_array`

## Requirements
- R1: While `clear` is high, `sw_en` is all zeros in the same cycle. From the next clock edge on, every stored bit is 0.
- R2: While `strobe` is high and `row_addr` is below 12, bit `sw_en[row_addr*8+col_addr]` equals `data` in the same cycle and follows it when it changes.
- R3: After `strobe` falls, the addressed bit holds the value `data` had at the last rising clock edge at which `strobe` was high.
- R4: A write changes only the addressed bit, and all other bits of `sw_en` keep their values.
- R5: The bit for row r and column c sits at index r*8+c of `sw_en`.
- R6: A strobe with a row code of 12, 13, 14 or 15 changes no bit of the array.
- R7: When `clear` and `strobe` are high in the same cycle, the clear wins. The addressed bit reads 0 and stays 0 after both inputs drop.
- R8: Any number of bits can be 1 at once, including every bit of one row and every bit of one column.
- R9: Writing 1 turns a bit on, and writing 0 to a bit that is on turns it off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the latch behaviour |
| clear | input | 1 | Active-high clear of all bits; also the reset |
| strobe | input | 1 | Active-high write enable for the addressed bit |
| row_addr | input | 4 | Row select, 0 to 11 valid |
| col_addr | input | 3 | Column select |
| data | input | 1 | Value written to the addressed bit |
| sw_en | output | 96 | Switch enables, index row*8+column |

## Verification
The assertions assume that the address stays fixed for as long as the strobe is high. If the address moved during a strobe, two bits could change between samples and the single-change property would not hold. The bench therefore changes the address only while the strobe is low, and every randomised burst ends with a strobe-low cycle before the next address is picked. The assertions also assume the clear input is high at the start, which the bench does first.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
    localparam int unsigned XPT_COLS  = 8;
    localparam int unsigned XPT_ROWS  = 12;
    localparam int unsigned XPT_COL_W = $clog2(XPT_COLS);
    localparam int unsigned XPT_ROW_W = 4;
    localparam int unsigned XPT_CELLS = XPT_COLS * XPT_ROWS;

    typedef struct packed {
        logic                 strobe;
        logic [XPT_ROW_W-1:0] row;
        logic [XPT_COL_W-1:0] col;
        logic                 data;
    } xpt_wr_t;

    function automatic int unsigned xpt_index(input int unsigned row,
                                              input int unsigned col);
        return row * XPT_COLS + col;
    endfunction
endpackage

// File: rtl/xpt_addr_decode.sv
module xpt_addr_decode
    import xpt_pkg::*;
#(
    parameter int unsigned COLS  = XPT_COLS,
    parameter int unsigned ROWS  = XPT_ROWS,
    localparam int unsigned CELLS = COLS * ROWS
) (
    input  xpt_wr_t          req,
    output logic [CELLS-1:0] sel
);
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            assign sel[r*COLS + c] = req.strobe
                                   && (req.row == XPT_ROW_W'(r))
                                   && (req.col == XPT_COL_W'(c));
        end
    end
endmodule

// File: rtl/xpt_cell.sv
module xpt_cell (
    input  logic clk,
    input  logic clear,
    input  logic en,
    input  logic data,
    output logic q_out
);
    logic held;

    always_ff @(posedge clk) begin
        if (clear)   held <= 1'b0;
        else if (en) held <= data;
    end

    always_comb begin
        if (clear)   q_out = 1'b0;
        else if (en) q_out = data;
        else         q_out = held;
    end
endmodule

// File: rtl/xpt_ctrl_array.sv
module xpt_ctrl_array
    import xpt_pkg::*;
#(
    parameter int unsigned COLS  = XPT_COLS,
    parameter int unsigned ROWS  = XPT_ROWS,
    localparam int unsigned CELLS = COLS * ROWS
) (
    input  logic                 clk,
    input  logic                 clear,
    input  logic                 strobe,
    input  logic [XPT_ROW_W-1:0] row_addr,
    input  logic [XPT_COL_W-1:0] col_addr,
    input  logic                 data,
    output logic [CELLS-1:0]     sw_en
);
    xpt_wr_t          req;
    logic [CELLS-1:0] sel;

    assign req = '{strobe: strobe, row: row_addr, col: col_addr, data: data};

    xpt_addr_decode #(.COLS(COLS), .ROWS(ROWS)) u_dec (
        .req (req),
        .sel (sel)
    );

    for (genvar i = 0; i < CELLS; i++) begin : g_cell
        xpt_cell u_cell (
            .clk   (clk),
            .clear (clear),
            .en    (sel[i]),
            .data  (req.data),
            .q_out (sw_en[i])
        );
    end
endmodule

// File: rtl/xpt_ctrl_chk.sv
module xpt_ctrl_chk
    import xpt_pkg::*;
#(
    parameter int unsigned COLS  = XPT_COLS,
    parameter int unsigned ROWS  = XPT_ROWS,
    localparam int unsigned CELLS = COLS * ROWS
) (
    input logic                 clk,
    input logic                 clear,
    input logic                 strobe,
    input logic [XPT_ROW_W-1:0] row_addr,
    input logic [XPT_COL_W-1:0] col_addr,
    input logic                 data,
    input logic [CELLS-1:0]     sw_en
);
    logic row_ok;
    assign row_ok = (int'(row_addr) < ROWS);

    // R1
    always_comb begin
        if (clear) begin
            clr_zero_chk: assert (sw_en == '0);
        end
    end

    // R2
    follow_data_chk: assert property (@(posedge clk) disable iff (clear)
        (strobe && row_ok) |-> (sw_en[int'(row_addr)*COLS + int'(col_addr)] == data));

    // R4
    idle_stable_chk: assert property (@(posedge clk) disable iff (clear)
        (!strobe && !$past(strobe) && !$past(clear)) |-> $stable(sw_en));

    // R4
    single_change_chk: assert property (@(posedge clk) disable iff (clear)
        !$past(clear) |-> ($countones(sw_en ^ $past(sw_en)) <= 1));

    // R6
    bad_row_chk: assert property (@(posedge clk) disable iff (clear)
        (strobe && !row_ok && $past(strobe) && (int'($past(row_addr)) >= ROWS)
         && !$past(clear)) |-> $stable(sw_en));

    // R7
    clear_wins_chk: assert property (@(posedge clk)
        $past(clear) && !clear && !strobe |-> (sw_en == '0));
endmodule

bind xpt_ctrl_array xpt_ctrl_chk #(.COLS(COLS), .ROWS(ROWS)) u_chk (
    .clk      (clk),
    .clear    (clear),
    .strobe   (strobe),
    .row_addr (row_addr),
    .col_addr (col_addr),
    .data     (data),
    .sw_en    (sw_en)
);

// File: tb/test_xpt_ctrl_array.sv
module test_xpt_ctrl_array;
    localparam int COLS  = 8;
    localparam int ROWS  = 12;
    localparam int CELLS = COLS * ROWS;

    logic             clk = 1'b0;
    logic             clear = 1'b1;
    logic             strobe = 1'b0;
    logic [3:0]       row_addr = '0;
    logic [2:0]       col_addr = '0;
    logic             data = 1'b0;
    logic [CELLS-1:0] sw_en;

    int checks = 0;
    int errors = 0;
    bit ref_q [CELLS];
    bit done = 0;

    always #4 clk = ~clk;

    xpt_ctrl_array i_xpt_ctrl_array (
        .clk(clk), .clear(clear), .strobe(strobe),
        .row_addr(row_addr), .col_addr(col_addr), .data(data), .sw_en(sw_en)
    );

    // behavioural model: state updates at each rising edge
    always @(posedge clk) begin
        if (clear) begin
            foreach (ref_q[i]) ref_q[i] = 0;
        end else if (strobe && row_addr < ROWS) begin
            ref_q[row_addr*COLS + col_addr] = data;
        end
    end

    function automatic logic [CELLS-1:0] expected();
        logic [CELLS-1:0] e;
        for (int i = 0; i < CELLS; i++) e[i] = ref_q[i];
        if (strobe && row_addr < ROWS) e[row_addr*COLS + col_addr] = data;
        if (clear) e = '0;
        return e;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [CELLS-1:0] act,
                       input logic [CELLS-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input bit c, input bit s, input int r, input int col,
                        input bit d, input string tag);
        @(negedge clk);
        clear = c; strobe = s; row_addr = 4'(r); col_addr = 3'(col); data = d;
        #1;
        chk(sw_en === expected(), tag, sw_en, expected());
    endtask

    task automatic bit_chk(input int idx, input bit v, input string tag);
        chk(sw_en[idx] === v, tag, CELLS'(sw_en[idx]), CELLS'(v));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [CELLS-1:0] snap;
        // R1 clear state
        for (int k = 0; k < 3; k++) step(1, 0, 0, 0, 0, "R1");
        chk(sw_en === '0, "R1", sw_en, '0);
        step(0, 0, 0, 0, 0, "R1");
        // R5 mapping: row 3, column 5 -> bit 29
        step(0, 1, 3, 5, 1, "R5");
        step(0, 0, 3, 5, 0, "R5");
        bit_chk(29, 1, "R5");
        chk(sw_en === (CELLS'(1) << 29), "R5", sw_en, CELLS'(1) << 29);
        // R2 transparency with toggling data
        step(0, 1, 7, 2, 1, "R2"); bit_chk(58, 1, "R2");
        step(0, 1, 7, 2, 0, "R2"); bit_chk(58, 0, "R2");
        step(0, 1, 7, 2, 1, "R2"); bit_chk(58, 1, "R2");
        // R3 capture of last strobed value
        step(0, 1, 7, 2, 0, "R3");
        step(0, 0, 7, 2, 1, "R3");
        bit_chk(58, 0, "R3");
        step(0, 1, 11, 7, 1, "R3");
        step(0, 0, 11, 7, 0, "R3");
        bit_chk(95, 1, "R3");
        // R8 full row 0 and full column 6
        for (int c = 0; c < COLS; c++) begin
            step(0, 1, 0, c, 1, "R8"); step(0, 0, 0, c, 0, "R8");
        end
        for (int r = 0; r < ROWS; r++) begin
            step(0, 1, r, 6, 1, "R8"); step(0, 0, r, 6, 0, "R8");
        end
        chk(sw_en[7:0] === 8'hFF, "R8", CELLS'(sw_en[7:0]), CELLS'(8'hFF));
        bit_chk(11*COLS + 6, 1, "R8");
        // R9 turn off one bit
        step(0, 1, 3, 5, 0, "R9"); step(0, 0, 3, 5, 1, "R9");
        bit_chk(29, 0, "R9");
        // R6 invalid rows leave everything unchanged
        snap = sw_en;
        for (int r = 12; r < 16; r++)
            for (int c = 0; c < COLS; c += 3) begin
                step(0, 1, r, c, 1, "R6"); step(0, 0, r, c, 0, "R6");
            end
        chk(sw_en === snap, "R6", sw_en, snap);
        // R4 neighbours unaffected by a write
        step(0, 1, 5, 1, 1, "R4"); step(0, 0, 5, 1, 0, "R4");
        chk((sw_en ^ snap) === (CELLS'(1) << 41), "R4", sw_en ^ snap, CELLS'(1) << 41);
        // R7 clear overrides strobe
        step(1, 1, 2, 2, 1, "R7");
        chk(sw_en === '0, "R7", sw_en, '0);
        step(0, 0, 2, 2, 1, "R7");
        bit_chk(18, 0, "R7");
        chk(sw_en === '0, "R1", sw_en, '0);
        // randomised bursts, address fixed while strobe high
        for (int k = 0; k < 400; k++) begin
            int r = $urandom_range(0, 15);
            int c = $urandom_range(0, 7);
            int n = $urandom_range(1, 3);
            bit cl = ($urandom_range(0, 40) == 0);
            for (int j = 0; j < n; j++)
                step(cl, 1, r, c, 1'($urandom_range(0, 1)), "R4");
            step(0, 0, r, c, 1'($urandom_range(0, 1)), "R3");
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule